// File: doc/BRIEF.md
# SPI Register Access Controller

This block is an SPI slave that lets a host processor reach a bank of 32 eight-bit control registers and issue direct commands. The host frames each transaction with an active-low slave select. It shifts bytes MSB first: it changes MOSI while SCLK is low and the slave samples on the rising SCLK edge. The block runs on its own system clock, which must be several times faster than SCLK, and it brings the SPI pins into that domain through a synchronizer.

The first byte of a frame is a control word. If its top bit is set, the word is a direct command, and the block emits a one-cycle strobe that carries the 5-bit command code. Otherwise the word names a register and says whether the access is a read or a write, and whether it is a single access or a streaming one. In single mode, control words and data bytes alternate for as long as the frame lasts. In streaming mode, every byte after the control word goes to the next register up, until slave select is released. Read data leaves on MISO, one byte behind the control word that asked for it. The contents of the bank drive the rest of the chip directly through a flat output bus.

Top module: `spi_regctl`

## Requirements
- R1: After reset, every register holds 0x00, MISO is low and the command strobe is low.
- R2: A control word with bit 7 = 1 produces exactly one single-cycle `cmd_valid` pulse, with `cmd_code` equal to bits 4..0 of the word. Bits 6 and 5 of such a word are ignored, no register changes, and the next byte is again a control word.
- R3: A control word with bit 7 = 0, bit 6 = 0 (write) and bit 5 = 0 (single) writes the following byte into the register addressed by bits 4..0. The byte after that is a new control word.
- R4: A control word with bit 7 = 0, bit 6 = 1 (read) and bit 5 = 0 makes MISO carry the addressed register, MSB first, during the following byte. The MOSI value of that byte changes no register.
- R5: A write word with bit 5 = 1 (streaming) writes each following byte of the frame to the start address, then start+1, start+2 and so on.
- R6: A read word with bit 5 = 1 returns consecutive registers on MISO, one per byte, starting at the addressed one.
- R7: In streaming mode the address goes from 31 back to 0.
- R8: MISO is low during every control-word byte and while slave select is high.
- R9: Raising slave select in the middle of a byte discards the partial byte, with no write and no command. The next frame starts again at bit 0 with a control word.
- R10: MOSI is sampled on the rising SCLK edge, MSB first. Eight rising edges make one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK by at least 8x |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low slave select framing a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| cmd_valid | output | 1 | One-cycle strobe for a direct command |
| cmd_code | output | 5 | Command code, valid while `cmd_valid` is high |
| ctrl_regs | output | 256 | Register bank, register n in bits [8n+7:8n] |

## Verification
A bit counter that has slipped shows up at once. Every later byte of the frame then decodes wrongly, and the bank bus shows a write landing in the wrong register, or a command strobe firing with a wrong code, within the next byte time. A stale frame phase or a stale address pointer shows up as a wrong MISO byte on the next read, or as a write to the wrong place on the next streamed byte. A transmit shifter that is not cleared makes MISO non-zero during a control word, which is visible in the first bit time of the next frame. After each transaction the bench compares the whole bank against its model. It checks every byte clocked out on MISO, and a scoreboard matches every command strobe against what was sent.

// File: rtl/spi_regctl_pkg.sv
package spi_regctl_pkg;

   // Where the frame parser stands within a transaction
   typedef enum logic {
      PH_WORD = 1'b0,   // next byte is a control/command word
      PH_DATA = 1'b1    // next byte is a data byte
   } phase_e;

   // Meaning of a decoded control word
   typedef struct packed {
      logic is_cmd;
      logic is_read;
      logic is_stream;
   } word_kind_t;

endpackage

// File: rtl/spi_regctl_sync.sv
module spi_regctl_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   logic [WIDTH-1:0] stg [STAGES];

   initial begin
      stages_min_chk: assert (STAGES >= 2)
         else $error("synchronizer needs at least two stages");
   end

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stg[STAGES-1];

endmodule

// File: rtl/spi_regctl_shifter.sv
module spi_regctl_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_data,
   output logic              active,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              miso
);

   localparam int CNT_W = $clog2(DATA_W);

   logic              sclk_q;
   logic              rise;
   logic [CNT_W-1:0]  bitcnt;
   logic [DATA_W-2:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;

   assign active    = ~cs_n_s;
   assign rise      = active & sclk_s & ~sclk_q;
   assign byte_done = rise & (bitcnt == CNT_W'(DATA_W-1));
   assign rx_byte   = {rx_sh, mosi_s};
   assign miso      = tx_sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         bitcnt <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
      end else begin
         sclk_q <= sclk_s;
         if (!active) begin
            bitcnt <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
         end else if (rise) begin
            bitcnt <= bitcnt + 1'b1;
            rx_sh  <= rx_byte[DATA_W-2:0];
            tx_sh  <= load_en ? load_data : {tx_sh[DATA_W-2:0], 1'b0};
         end
      end
   end

   // R10: a completed byte needs fresh SCLK edges, so two in a row are impossible
   byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

   // R8: with slave select released, MISO is low on the following cycle
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !miso);

endmodule

// File: rtl/spi_regctl_ctrl.sv
module spi_regctl_ctrl
   import spi_regctl_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int CODE_W    = 5,
   parameter bit WRAP_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              load_en,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              cmd_valid,
   output logic [CODE_W-1:0] cmd_code
);

   localparam int CMD_BIT  = DATA_W - 1;
   localparam int RD_BIT   = DATA_W - 2;
   localparam int STRM_BIT = DATA_W - 3;
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'((1 << ADDR_W) - 1);

   phase_e            phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic              rd_q;
   logic              strm_q;
   word_kind_t        kind;

   assign kind.is_cmd    = rx_byte[CMD_BIT];
   assign kind.is_read   = rx_byte[RD_BIT];
   assign kind.is_stream = rx_byte[STRM_BIT];

   // Address step for streaming mode: variant chosen by parameter
   generate
      if (WRAP_ADDR) begin : g_wrap
         assign addr_nxt = addr_q + 1'b1;

         // R5 R7: each streamed byte advances the pointer by one, modulo the bank size
         stream_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_done && phase_q == PH_DATA && strm_q) |=> (addr_q == $past(addr_q) + 1'b1));
      end else begin : g_sat
         assign addr_nxt = (addr_q == TOP_ADDR) ? addr_q : addr_q + 1'b1;
      end
   endgenerate

   always_comb begin
      load_en = 1'b0;
      rd_addr = addr_nxt;
      if (byte_done) begin
         if (phase_q == PH_WORD) begin
            load_en = ~kind.is_cmd & kind.is_read;
            rd_addr = rx_byte[ADDR_W-1:0];
         end else begin
            load_en = rd_q & strm_q;
         end
      end
   end

   assign wr_en   = byte_done & (phase_q == PH_DATA) & ~rd_q;
   assign wr_addr = addr_q;
   assign wr_data = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_WORD;
         addr_q    <= '0;
         rd_q      <= 1'b0;
         strm_q    <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_code  <= '0;
      end else begin
         cmd_valid <= 1'b0;
         if (!active) begin
            phase_q <= PH_WORD;
            rd_q    <= 1'b0;
            strm_q  <= 1'b0;
         end else if (byte_done) begin
            if (phase_q == PH_WORD) begin
               if (kind.is_cmd) begin
                  cmd_valid <= 1'b1;
                  cmd_code  <= rx_byte[CODE_W-1:0];
               end else begin
                  phase_q <= PH_DATA;
                  addr_q  <= rx_byte[ADDR_W-1:0];
                  rd_q    <= kind.is_read;
                  strm_q  <= kind.is_stream;
               end
            end else if (strm_q) begin
               addr_q <= addr_nxt;
            end else begin
               phase_q <= PH_WORD;
            end
         end
      end
   end

   // R2: a command strobe lasts a single cycle
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R9: releasing slave select returns the parser to the control-word phase
   abort_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (phase_q == PH_WORD));

   // R3: in single mode a data byte is followed by a control word
   single_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase_q == PH_DATA && !strm_q) |=> (phase_q == PH_WORD));

endmodule

// File: rtl/spi_regctl_bank.sv
module spi_regctl_bank #(
   parameter int              DATA_W  = 8,
   parameter int              ADDR_W  = 5,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   output logic [(1<<ADDR_W)*DATA_W-1:0] bank_o
);

   localparam int NREG = 1 << ADDR_W;

   logic [DATA_W-1:0] regs [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   regs[i] <= RST_VAL;
            else if (wr_en && wr_addr == ADDR_W'(i))      regs[i] <= wr_data;
         end
         assign bank_o[i*DATA_W +: DATA_W] = regs[i];

         // R3 R5: a write lands in its addressed register on the next cycle
         wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(i)) |=> (regs[i] == $past(wr_data)));

         // R4: without a write strobe the register keeps its value
         hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(i)) |=> $stable(regs[i]));
      end
   endgenerate

   assign rd_data = regs[rd_addr];

endmodule

// File: rtl/spi_regctl.sv
module spi_regctl #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int CODE_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit WRAP_ADDR   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          spi_sclk,
   input  logic                          spi_cs_n,
   input  logic                          spi_mosi,
   output logic                          spi_miso,
   output logic                          cmd_valid,
   output logic [CODE_W-1:0]             cmd_code,
   output logic [(1<<ADDR_W)*DATA_W-1:0] ctrl_regs
);

   localparam int NREG = 1 << ADDR_W;

   initial begin
      addr_fit_chk: assert (ADDR_W <= DATA_W - 3)
         else $error("address field overlaps the mode bits of the control word");
      code_fit_chk: assert (CODE_W <= DATA_W - 3)
         else $error("command code overlaps the mode bits of the control word");
      bank_size_chk: assert (NREG >= 2)
         else $error("bank needs at least two registers");
   end

   logic              cs_n_s, sclk_s, mosi_s;
   logic              active, byte_done, load_en, wr_en;
   logic [DATA_W-1:0] rx_byte, rd_data, wr_data;
   logic [ADDR_W-1:0] rd_addr, wr_addr;

   spi_regctl_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({spi_cs_n, spi_sclk, spi_mosi}),
      .d_out ({cs_n_s, sclk_s, mosi_s})
   );

   spi_regctl_shifter #(
      .DATA_W (DATA_W)
   ) i_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .cs_n_s    (cs_n_s),
      .mosi_s    (mosi_s),
      .load_en   (load_en),
      .load_data (rd_data),
      .active    (active),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .miso      (spi_miso)
   );

   spi_regctl_ctrl #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CODE_W    (CODE_W),
      .WRAP_ADDR (WRAP_ADDR)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .rd_addr   (rd_addr),
      .load_en   (load_en),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code)
   );

   spi_regctl_bank #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .RST_VAL ('0)
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .bank_o  (ctrl_regs)
   );

   // R1: command strobe and MISO are quiet in the first cycle out of reset
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!cmd_valid && !spi_miso));

endmodule

// File: tb/test_spi_regctl.sv
module test_spi_regctl;

   logic         clk = 1'b0;
   logic         rst_n, sclk, cs_n, mosi;
   logic         miso, cmd_valid;
   logic [4:0]   cmd_code;
   logic [255:0] ctrl_regs;

   int           n_vec = 0;
   int           n_bad = 0;
   logic [7:0]   model [32];
   logic [4:0]   cmd_q [$];
   logic         prev_valid = 1'b0;

   always #5 clk = ~clk;

   spi_regctl i_spi_regctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sclk  (sclk),
      .spi_cs_n  (cs_n),
      .spi_mosi  (mosi),
      .spi_miso  (miso),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .ctrl_regs (ctrl_regs)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_bank(input string tag);
      logic [255:0] exp;
      for (int i = 0; i < 32; i++) exp[i*8 +: 8] = model[i];
      n_vec++;
      if (ctrl_regs !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, ctrl_regs, exp);
      end
   endtask

   // One byte, MSB first: MOSI set while SCLK low, MISO sampled just before the rise
   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         #80;
         rx[i] = miso;
         sclk = 1'b1;
         #80;
         sclk = 1'b0;
      end
   endtask

   task automatic frame_open();
      cs_n = 1'b0;
      #40;
   endtask

   task automatic frame_close();
      #40;
      cs_n = 1'b1;
      #100;
   endtask

   // Control-word byte; MISO must stay low throughout (R8)
   task automatic send_word(input logic [7:0] w);
      logic [7:0] r;
      xfer(w, r);
      chk("R8 MISO low during control word", {24'd0, r}, 32'd0);
   endtask

   task automatic send_cmd(input logic [7:0] w);
      cmd_q.push_back(w[4:0]);
      send_word(w);
   endtask

   // Scoreboard monitor for command strobes (R2)
   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid) begin
            n_vec++;
            if (cmd_q.size() == 0) begin
               n_bad++;
               $display("FAIL R2 unexpected strobe: actual %h expected none", cmd_code);
            end else begin
               logic [4:0] e;
               e = cmd_q.pop_front();
               if (cmd_code !== e) begin
                  n_bad++;
                  $display("FAIL R2 command code: actual %h expected %h", cmd_code, e);
               end
            end
            if (prev_valid) begin
               n_bad++;
               $display("FAIL R2 strobe width: actual 2+ cycles expected 1");
            end
         end
         prev_valid = cmd_valid;
      end
   end

   initial begin
      #1_000_000;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
      #3;
      #100;
      rst_n = 1'b1;
      #50;

      // R1 reset state
      chk_bank("R1 reset bank");
      chk("R1 reset miso", {31'd0, miso}, 32'd0);
      chk("R1 reset strobe", {31'd0, cmd_valid}, 32'd0);

      // R3 R10 single writes, two pairs in one frame
      frame_open();
      send_word(8'h03); xfer(8'hA5, r); model[3] = 8'hA5;
      send_word(8'h1C); xfer(8'h3C, r); model[28] = 8'h3C;
      frame_close();
      chk_bank("R3 R10 single write pairs");

      // R4 single read with non-zero dummy byte, then a write in the same frame
      frame_open();
      send_word(8'h43); xfer(8'hFF, r);
      chk("R4 single read reg3", {24'd0, r}, 32'h0000_00A5);
      send_word(8'h05); xfer(8'h81, r); model[5] = 8'h81;
      send_word(8'h5C); xfer(8'h00, r);
      chk("R4 single read reg28", {24'd0, r}, 32'h0000_003C);
      frame_close();
      chk_bank("R4 dummy MOSI changes nothing");

      // R2 commands, bits 6..5 ignored, mixed with register access
      frame_open();
      send_cmd(8'h91);
      send_cmd(8'hE5);
      send_word(8'h07); xfer(8'h77, r); model[7] = 8'h77;
      send_cmd(8'hBF);
      frame_close();
      chk_bank("R2 commands leave bank alone");
      chk("R2 all strobes seen", cmd_q.size(), 32'd0);

      // R5 streaming write
      frame_open();
      send_word(8'h30);
      for (int k = 0; k < 4; k++) begin
         xfer(8'h10 + 8'(k * 17), r);
         model[16 + k] = 8'h10 + 8'(k * 17);
      end
      frame_close();
      chk_bank("R5 streaming write");

      // R6 streaming read
      frame_open();
      send_word(8'h70);
      for (int k = 0; k < 4; k++) begin
         xfer(8'h00, r);
         chk("R6 streaming read", {24'd0, r}, {24'd0, model[16 + k]});
      end
      frame_close();

      // R7 wrap on streaming write and read
      frame_open();
      send_word(8'h3E);
      xfer(8'hE1, r); model[30] = 8'hE1;
      xfer(8'hF1, r); model[31] = 8'hF1;
      xfer(8'h0D, r); model[0]  = 8'h0D;
      frame_close();
      chk_bank("R7 streaming write wraps");
      frame_open();
      send_word(8'h7F);
      xfer(8'h00, r); chk("R7 read reg31", {24'd0, r}, 32'h0000_00F1);
      xfer(8'h00, r); chk("R7 read wraps to reg0", {24'd0, r}, 32'h0000_000D);
      frame_close();

      // R9 aborted partial byte: 3 bits of a would-be command, then release
      frame_open();
      for (int i = 7; i >= 5; i--) begin
         mosi = 1'b1; #80; sclk = 1'b1; #80; sclk = 1'b0;
      end
      frame_close();
      chk("R8 MISO low with select released", {31'd0, miso}, 32'd0);
      // after a partial data byte of a write
      frame_open();
      send_word(8'h09);
      for (int i = 7; i >= 4; i--) begin
         mosi = 1'b1; #80; sclk = 1'b1; #80; sclk = 1'b0;
      end
      frame_close();
      chk_bank("R9 partial byte discarded");
      frame_open();
      send_word(8'h09); xfer(8'h5A, r); model[9] = 8'h5A;
      frame_close();
      chk_bank("R9 next frame realigned");
      chk("R9 no stray command", cmd_q.size(), 32'd0);

      #200;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule